// File: doc/BRIEF.md
# Secondary Interrupt Fan-In Controller

This block gathers up to 32 level-sensitive interrupt sources on behalf of a primary interrupt controller. Each source has an enable bit. Software changes the enable bits only through two strobe registers. One register sets the enable of each source whose data bit is 1. The other clears the enable of each such source. No read-modify-write is ever needed. Clearing a source's enable is also how its interrupt is acknowledged, because the sources are level-held. A status register shows the sources that are both pending and enabled.

Every enabled, pending source that is not diverted is ORed into a single combined line. That line is wired to input 31 of the primary controller. The sources numbered 21 to 31 can also be diverted one at a time by a pass-through register. A diverted source leaves the combined line and drives its own direct line, which goes to the primary-controller input with the same number. Reads and writes on the register bus finish in the cycle they are presented, with no wait states.

Top module: `irq_fanin_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all enable bits and all pass-through bits are 0. With any source pattern, `combined_irq` and every `direct_irq` bit are then 0.
- R2: A write to word address 3 (enable-set) sets the enable of each source whose `bus_wdata` bit is 1 and leaves the other enables unchanged. The new enables are visible from the clock edge that takes the write.
- R3: A write to word address 4 (enable-clear) clears the enable of each source whose `bus_wdata` bit is 1 and leaves the other enables unchanged. Writing all ones clears every enable.
- R4: A read of word address 0 (status) returns `src_level` AND the enable bits, so it is zero when no enabled source is active.
- R5: `combined_irq` is 1 exactly when some source is active, enabled and has its pass-through bit at 0.
- R6: `direct_irq[k]` is 1 exactly when source 21+k is active, enabled and has its pass-through bit set. A diverted source never reaches `combined_irq`.
- R7: A write to word address 5 (pass-through) loads bits 21 to 31. Bits 0 to 20 always read 0 and ignore writes, so writing 0xFFD00000 reads back 0xFFC00000.
- R8: A read of word address 2 returns the enable bits. A read of word address 1 returns the raw `src_level`. Reads of addresses 3 and 4 return 0.
- R9: Writes to addresses 0, 1, 2, 6 and 7 change neither the enable bits nor the pass-through bits.
- R10: Reads of addresses 6 and 7 return 0, and `bus_rdata` is 0 whenever no read is presented (`bus_sel` low or `bus_wr` high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data, one bit per source |
| bus_rdata | output | 32 | Read data, valid in the same cycle |
| src_level | input | 32 | Level-sensitive interrupt sources |
| combined_irq | output | 1 | OR of enabled, pending, non-diverted sources |
| direct_irq | output | 11 | Direct lines for sources 21 to 31 (bit k is source 21+k) |

## Verification
The bench checks that the set and clear strobes touch only the bits written. A design doing a plain load would wipe enables that were written earlier. It writes the example mask 0xFFD00000, whose bit 20 falls in the hardwired range. A design with a full-width pass register would read back 0xFFD00000 instead of 0xFFC00000. It also enables a diverted source and looks for the source on its own direct line but not on the combined line, which catches a leaky OR. Finally, it removes the enable of a diverted source, which catches a direct line that is gated only by the pass-through bit.

// File: rtl/irq_fanin_pkg.sv
// Shared constants and register address map for the interrupt fan-in controller.
// Assumes a 3-bit word address bus; the map is fixed by software convention.
package irq_fanin_pkg;
    localparam int unsigned SRC_COUNT  = 32;
    localparam int unsigned DIRECT_MIN = 21;
    localparam int unsigned ADDR_W     = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_STATUS = 3'd0,
        RA_RAW    = 3'd1,
        RA_ENABLE = 3'd2,
        RA_EN_SET = 3'd3,
        RA_EN_CLR = 3'd4,
        RA_PASS   = 3'd5
    } reg_addr_e;
endpackage

// File: rtl/irq_fanin_regs.sv
// Enable and pass-through state for the fan-in controller.
// The enables change only through set and clear strobes; when both touch a bit,
// the clear wins. Pass-through bits below DIRECT_MIN are constant zero.
// Assumes write strobes are single-cycle and already decoded.
module irq_fanin_regs #(
    parameter int unsigned SRC_COUNT  = 32,
    parameter int unsigned DIRECT_MIN = 21
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_stb,
    input  logic                 clr_stb,
    input  logic                 pass_stb,
    input  logic [SRC_COUNT-1:0] wdata,
    output logic [SRC_COUNT-1:0] en_q,
    output logic [SRC_COUNT-1:0] pass_q
);
    logic [SRC_COUNT-1:0] set_mask;
    logic [SRC_COUNT-1:0] clr_mask;

    // Gate the write data into per-strobe bit masks.
    always_comb begin
        set_mask = set_stb ? wdata : '0;
        clr_mask = clr_stb ? wdata : '0;
    end

    // Enable register: OR in set bits, then knock out clear bits.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= (en_q | set_mask) & ~clr_mask;
    end

    // Pass-through bits: flops only where a direct line exists.
    for (genvar i = 0; i < SRC_COUNT; i++) begin : g_pass
        if (i < DIRECT_MIN) begin : g_fixed
            assign pass_q[i] = 1'b0;
        end else begin : g_flop
            logic bit_q;
            // Load this pass-through bit on a pass register write.
            always_ff @(posedge clk) begin
                if (!rst_n)       bit_q <= 1'b0;
                else if (pass_stb) bit_q <= wdata[i];
            end
            assign pass_q[i] = bit_q;
        end
    end

    // R2: every bit written to the set register is enabled afterwards
    p_set_applies_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (set_stb && !clr_stb) |=> ((en_q & $past(wdata)) == $past(wdata)));

    // R3: every bit written to the clear register is disabled afterwards
    p_clr_applies_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stb |=> ((en_q & $past(wdata)) == '0));

    // R9: without a set or clear strobe the enables hold
    p_en_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_stb && !clr_stb) |=> $stable(en_q));

    // R9: without a pass write the pass-through bits hold
    p_pass_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pass_stb |=> $stable(pass_q));
endmodule

// File: rtl/irq_fanin_route.sv
// Output routing: splits enabled pending sources between the combined line and
// the direct lines. Purely combinational; assumes sources are level-held.
module irq_fanin_route #(
    parameter int unsigned SRC_COUNT  = 32,
    parameter int unsigned DIRECT_MIN = 21,
    localparam int unsigned DIRECT_N  = SRC_COUNT - DIRECT_MIN
) (
    input  logic [SRC_COUNT-1:0] src_level,
    input  logic [SRC_COUNT-1:0] en_q,
    input  logic [SRC_COUNT-1:0] pass_q,
    output logic                 combined_irq,
    output logic [DIRECT_N-1:0]  direct_irq
);
    logic [SRC_COUNT-1:0] live;

    // Sources that are both pending and enabled.
    always_comb live = src_level & en_q;

    // Non-diverted live sources are merged into one line.
    always_comb combined_irq = |(live & ~pass_q);

    // One direct line per divertible source.
    for (genvar k = 0; k < DIRECT_N; k++) begin : g_direct
        assign direct_irq[k] = live[DIRECT_MIN+k] & pass_q[DIRECT_MIN+k];
    end
endmodule

// File: rtl/irq_fanin_rdmux.sv
// Read-data multiplexer. Returns zero when no read is presented or the
// address is unmapped; the set and clear registers read as zero.
module irq_fanin_rdmux
    import irq_fanin_pkg::*;
#(
    parameter int unsigned SRC_COUNT = 32
) (
    input  logic                 rd_stb,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [SRC_COUNT-1:0] status,
    input  logic [SRC_COUNT-1:0] raw,
    input  logic [SRC_COUNT-1:0] en_q,
    input  logic [SRC_COUNT-1:0] pass_q,
    output logic [SRC_COUNT-1:0] rdata
);
    // Select the addressed word for a read.
    always_comb begin
        rdata = '0;
        if (rd_stb) begin
            case (reg_addr_e'(addr))
                RA_STATUS: rdata = status;
                RA_RAW:    rdata = raw;
                RA_ENABLE: rdata = en_q;
                RA_PASS:   rdata = pass_q;
                default:   rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/irq_fanin_ctrl.sv
// Top of the secondary interrupt fan-in controller. Decodes the single-cycle
// register bus, holds enables and pass-through bits, and drives the combined
// line and the direct lines. Assumes bus_sel/bus_wr are synchronous to clk.
module irq_fanin_ctrl
    import irq_fanin_pkg::*;
#(
    parameter int unsigned SRC_COUNT  = irq_fanin_pkg::SRC_COUNT,
    parameter int unsigned DIRECT_MIN = irq_fanin_pkg::DIRECT_MIN,
    localparam int unsigned DIRECT_N  = SRC_COUNT - DIRECT_MIN
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [SRC_COUNT-1:0] bus_wdata,
    output logic [SRC_COUNT-1:0] bus_rdata,
    input  logic [SRC_COUNT-1:0] src_level,
    output logic                 combined_irq,
    output logic [DIRECT_N-1:0]  direct_irq
);
    logic                 wr_stb, rd_stb;
    logic                 set_stb, clr_stb, pass_stb;
    logic [SRC_COUNT-1:0] en_q, pass_q, status;

    // Decode the bus cycle into per-register strobes.
    always_comb begin
        wr_stb   = bus_sel & bus_wr;
        rd_stb   = bus_sel & ~bus_wr;
        set_stb  = wr_stb & (bus_addr == RA_EN_SET);
        clr_stb  = wr_stb & (bus_addr == RA_EN_CLR);
        pass_stb = wr_stb & (bus_addr == RA_PASS);
    end

    // Status word seen by software.
    always_comb status = src_level & en_q;

    irq_fanin_regs #(.SRC_COUNT(SRC_COUNT), .DIRECT_MIN(DIRECT_MIN)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_stb  (set_stb),
        .clr_stb  (clr_stb),
        .pass_stb (pass_stb),
        .wdata    (bus_wdata),
        .en_q     (en_q),
        .pass_q   (pass_q)
    );

    irq_fanin_route #(.SRC_COUNT(SRC_COUNT), .DIRECT_MIN(DIRECT_MIN)) u_route (
        .src_level    (src_level),
        .en_q         (en_q),
        .pass_q       (pass_q),
        .combined_irq (combined_irq),
        .direct_irq   (direct_irq)
    );

    irq_fanin_rdmux #(.SRC_COUNT(SRC_COUNT)) u_rdmux (
        .rd_stb (rd_stb),
        .addr   (bus_addr),
        .status (status),
        .raw    (src_level),
        .en_q   (en_q),
        .pass_q (pass_q),
        .rdata  (bus_rdata)
    );

    // R5: the combined line needs some enabled pending source behind it
    p_comb_needs_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
        combined_irq |-> (status != '0));

    // R6: a direct line needs its own source enabled and pending
    for (genvar k = 0; k < DIRECT_N; k++) begin : g_chk_direct
        p_direct_needs_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
            direct_irq[k] |-> status[DIRECT_MIN+k]);
    end

    // R10: read data is quiet when no read is presented
    p_rdata_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |-> (bus_rdata == '0));
endmodule

// File: tb/irq_fanin_ctrl_bench.sv
// Directed bench for irq_fanin_ctrl: one task per scenario.
module irq_fanin_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] src_level = '0;
    logic        combined_irq;
    logic [10:0] direct_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_fanin_ctrl u_irq_fanin_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_level(src_level), .combined_irq(combined_irq), .direct_irq(direct_irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        src_level = 32'hFFFF_FFFF;
        #1;
        check("R1 combined after reset", {31'd0, combined_irq}, 32'd0);
        check("R1 direct after reset", {21'd0, direct_irq}, 32'd0);
        rd(3'd2, v); check("R1 enable after reset", v, 32'd0);
        rd(3'd5, v); check("R1 pass after reset", v, 32'd0);
        #1 check("R10 idle rdata", bus_rdata, 32'd0);
        src_level = '0;
    endtask

    task automatic t_set();
        logic [31:0] v;
        wr(3'd3, 32'h0000_00F0);
        rd(3'd2, v); check("R2 first set", v, 32'h0000_00F0);
        wr(3'd3, 32'h0000_0F00);
        rd(3'd2, v); check("R2 set keeps others", v, 32'h0000_0FF0);
    endtask

    task automatic t_clear();
        logic [31:0] v;
        wr(3'd4, 32'h0000_0030);
        rd(3'd2, v); check("R3 partial clear", v, 32'h0000_0FC0);
    endtask

    task automatic t_status();
        logic [31:0] v;
        src_level = 32'hA5A5_0F0F;
        rd(3'd0, v); check("R4 status", v, 32'hA5A5_0F0F & 32'h0000_0FC0);
        rd(3'd1, v); check("R8 raw levels", v, 32'hA5A5_0F0F);
        src_level = 32'h0000_F000;
        rd(3'd0, v); check("R4 status zero", v, 32'd0);
        src_level = '0;
    endtask

    task automatic t_combined();
        src_level = 32'h0000_0040;
        #1 check("R5 combined on", {31'd0, combined_irq}, 32'd1);
        src_level = 32'h0000_0001;
        #1 check("R5 disabled source", {31'd0, combined_irq}, 32'd0);
        src_level = '0;
    endtask

    task automatic t_pass();
        logic [31:0] v;
        wr(3'd5, 32'hFFFF_FFFF);
        rd(3'd5, v); check("R7 low pass bits fixed", v, 32'hFFE0_0000);
        wr(3'd3, 32'h0220_0000);
        src_level = 32'h0200_0000;
        #1 check("R6 diverted off combined", {31'd0, combined_irq}, 32'd0);
        check("R6 direct line 25", {21'd0, direct_irq}, 32'h0000_0010);
        wr(3'd5, 32'hFFD0_0000);
        rd(3'd5, v); check("R7 example mask", v, 32'hFFC0_0000);
        src_level = 32'h0020_0000;
        #1 check("R5 source 21 back on combined", {31'd0, combined_irq}, 32'd1);
        check("R6 direct 21 off", {21'd0, direct_irq}, 32'd0);
        wr(3'd4, 32'h0200_0000);
        src_level = 32'h0200_0000;
        #1 check("R6 direct gated by enable", {21'd0, direct_irq}, 32'd0);
        check("R5 disabled diverted", {31'd0, combined_irq}, 32'd0);
        src_level = '0;
    endtask

    task automatic t_readonly();
        logic [31:0] v;
        rd(3'd3, v); check("R8 set reads zero", v, 32'd0);
        rd(3'd4, v); check("R8 clear reads zero", v, 32'd0);
        rd(3'd6, v); check("R10 addr 6 zero", v, 32'd0);
        rd(3'd7, v); check("R10 addr 7 zero", v, 32'd0);
        for (int a = 0; a < 8; a++) begin
            if (a == 0 || a == 1 || a == 2 || a == 6 || a == 7) wr(a[2:0], 32'hFFFF_FFFF);
        end
        rd(3'd2, v); check("R9 enable untouched", v, 32'h0020_0FC0);
        rd(3'd5, v); check("R9 pass untouched", v, 32'hFFC0_0000);
    endtask

    task automatic t_clear_all();
        logic [31:0] v;
        wr(3'd4, 32'hFFFF_FFFF);
        rd(3'd2, v); check("R3 clear all", v, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_set();
        t_clear();
        t_status();
        t_combined();
        t_pass();
        t_readonly();
        t_clear_all();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule